// File: doc/BRIEF.md
# Predicated Vector Writeback

This block sits at the end of a vector execution pipe and decides, element by element, what reaches the destination. It takes a wide computed vector, the previous contents of the destination and a per-element predicate mask. Elements whose predicate bit is set receive the computed value. The other elements either keep their old value (merge) or are cleared (zero). The element width is selectable, and only as many low mask bits as there are elements take part.

For a destination in memory the block produces per-byte write strobes covering enabled elements only. Clearing is not permitted there: such a request raises an illegal-combination flag and writes nothing. Per-element exception flags and memory fault indications from elements that are switched off are dropped. The exception flags that remain are reduced to a single summary bit. The surviving fault indications are passed on as a vector. A parameter selects a purely combinational path or one output register stage.

Top module: `vec_pred_writeback`

## Requirements
- R1: `esize` encodes the element width as 0=8, 1=16, 2=32 or 3=64 bits, giving VBITS/8, VBITS/16, VBITS/32 or VBITS/64 elements. Element i occupies bytes i*W .. i*W+W-1, where W is the width in bytes. Only mask bits below the element count take part, so with `esize`=3 mask bits 63:8, exception bits 63:8 and fault bits 63:8 have no effect on any output.
- R2: A data byte of an element whose mask bit is 1 equals the corresponding byte of `result`.
- R3: A data byte of an element whose mask bit is 0 equals the corresponding byte of `old_dst` when `zero_mode`=0, or whenever `dst_mem`=1.
- R4: A data byte of an element whose mask bit is 0 is 0x00 when `zero_mode`=1 and `dst_mem`=0.
- R5: With `dst_mem`=1 and `zero_mode`=0, `byte_en[b]` is 1 exactly when byte b belongs to an enabled element. With `dst_mem`=0, `byte_en` is all zero.
- R6: With `zero_mode`=1 and `dst_mem`=1 on a valid request, `illegal_mode` is 1 and `byte_en` is all zero. Otherwise `illegal_mode` is 0.
- R7: `exc_any` is the OR of `elem_exc[i]` over enabled elements only.
- R8: `fault_kept[i]` equals `elem_fault[i]` AND the enabled state of element i.
- R9: With every mask bit set, `wr_data` equals `result` in every mode and for either destination.
- R10: With OUT_REG=1, all outputs follow their inputs by one clock and reset clears them. With OUT_REG=0, they follow in the same cycle.
- R11: When `out_valid` is 0, `byte_en`, `exc_any`, `fault_kept` and `illegal_mode` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| esize | input | 2 | Element width code |
| zero_mode | input | 1 | 1 = clear masked-off elements, 0 = keep them |
| dst_mem | input | 1 | Destination is memory |
| mask | input | VBITS/8 | Per-element predicate |
| result | input | VBITS | Computed vector |
| old_dst | input | VBITS | Previous destination contents |
| elem_exc | input | VBITS/8 | Per-element exception flags |
| elem_fault | input | VBITS/8 | Per-element memory fault flags |
| out_valid | output | 1 | Outputs carry a request |
| wr_data | output | VBITS | Merged write data |
| byte_en | output | VBITS/8 | Memory byte strobes |
| exc_any | output | 1 | OR of exceptions of enabled elements |
| fault_kept | output | VBITS/8 | Faults of enabled elements |
| illegal_mode | output | 1 | Clear requested for a memory destination |

## Verification
The bench builds two copies at VBITS=512: one with OUT_REG=1 and one with OUT_REG=0. Running both covers the one-cycle registered timing and the same-cycle path against the same stimulus. The full 64-element width makes the high mask, exception and fault bits reachable, so the way narrower element sizes ignore those bits can be observed. All four element widths are crossed with both modes and both destinations.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    typedef enum logic [1:0] {
        ESZ_B8  = 2'd0,
        ESZ_B16 = 2'd1,
        ESZ_B32 = 2'd2,
        ESZ_B64 = 2'd3
    } esize_e;

endpackage

// File: rtl/vpw_mask_expand.sv
module vpw_mask_expand #(
    parameter int NBYTES = 64
) (
    input  vpw_pkg::esize_e    esize,
    input  logic [NBYTES-1:0]  mask,
    output logic [NBYTES-1:0]  elem_live,
    output logic [NBYTES-1:0]  byte_live
);
    import vpw_pkg::*;

    // element slot i is live when its mask bit is set and it lies within the element count
    for (genvar i = 0; i < NBYTES; i++) begin : g_elem
        always_comb begin
            unique case (esize)
                ESZ_B8:  elem_live[i] = mask[i];
                ESZ_B16: elem_live[i] = (i < NBYTES / 2) ? mask[i] : 1'b0;
                ESZ_B32: elem_live[i] = (i < NBYTES / 4) ? mask[i] : 1'b0;
                default: elem_live[i] = (i < NBYTES / 8) ? mask[i] : 1'b0;
            endcase
        end
    end

    // byte b takes the state of the element that covers it
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_comb begin
            unique case (esize)
                ESZ_B8:  byte_live[b] = elem_live[b];
                ESZ_B16: byte_live[b] = elem_live[b / 2];
                ESZ_B32: byte_live[b] = elem_live[b / 4];
                default: byte_live[b] = elem_live[b / 8];
            endcase
        end
    end

endmodule

// File: rtl/vpw_byte_merge.sv
module vpw_byte_merge #(
    parameter int NBYTES = 64,
    localparam int DBITS = NBYTES * 8
) (
    input  logic [DBITS-1:0]  result,
    input  logic [DBITS-1:0]  old_dst,
    input  logic [NBYTES-1:0] byte_live,
    input  logic              zero_fill,
    output logic [DBITS-1:0]  merged
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        always_comb begin
            if (byte_live[b]) begin
                merged[b*8 +: 8] = result[b*8 +: 8];
            end else if (zero_fill) begin
                merged[b*8 +: 8] = 8'h00;
            end else begin
                merged[b*8 +: 8] = old_dst[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/vpw_status.sv
module vpw_status #(
    parameter int NBYTES = 64
) (
    input  logic [NBYTES-1:0] elem_live,
    input  logic [NBYTES-1:0] elem_exc,
    input  logic [NBYTES-1:0] elem_fault,
    output logic              exc_raw,
    output logic [NBYTES-1:0] fault_raw
);

    always_comb begin
        exc_raw   = |(elem_exc & elem_live);
        fault_raw = elem_fault & elem_live;
    end

endmodule

// File: rtl/vec_pred_writeback.sv
module vec_pred_writeback #(
    parameter int VBITS   = 512,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           esize,
    input  logic                 zero_mode,
    input  logic                 dst_mem,
    input  logic [VBITS/8-1:0]   mask,
    input  logic [VBITS-1:0]     result,
    input  logic [VBITS-1:0]     old_dst,
    input  logic [VBITS/8-1:0]   elem_exc,
    input  logic [VBITS/8-1:0]   elem_fault,
    output logic                 out_valid,
    output logic [VBITS-1:0]     wr_data,
    output logic [VBITS/8-1:0]   byte_en,
    output logic                 exc_any,
    output logic [VBITS/8-1:0]   fault_kept,
    output logic                 illegal_mode
);
    import vpw_pkg::*;

    localparam int NBYTES = VBITS / 8;

    typedef struct packed {
        logic              vld;
        logic [VBITS-1:0]  data;
        logic [NBYTES-1:0] ben;
        logic              exc;
        logic [NBYTES-1:0] flt;
        logic              ill;
    } wb_t;

    wb_t               wb_d;
    wb_t               wb_q;
    esize_e            esize_t;
    logic [NBYTES-1:0] elem_live;
    logic [NBYTES-1:0] byte_live;
    logic [VBITS-1:0]  merged;
    logic              exc_raw;
    logic [NBYTES-1:0] fault_raw;
    logic              zero_fill;

    assign esize_t   = esize_e'(esize);
    assign zero_fill = zero_mode & ~dst_mem;

    vpw_mask_expand #(.NBYTES(NBYTES)) u_expand (
        .esize     (esize_t),
        .mask      (mask),
        .elem_live (elem_live),
        .byte_live (byte_live)
    );

    vpw_byte_merge #(.NBYTES(NBYTES)) u_merge (
        .result    (result),
        .old_dst   (old_dst),
        .byte_live (byte_live),
        .zero_fill (zero_fill),
        .merged    (merged)
    );

    vpw_status #(.NBYTES(NBYTES)) u_status (
        .elem_live  (elem_live),
        .elem_exc   (elem_exc),
        .elem_fault (elem_fault),
        .exc_raw    (exc_raw),
        .fault_raw  (fault_raw)
    );

    always_comb begin
        wb_d      = '0;
        wb_d.vld  = in_valid;
        wb_d.data = merged;
        wb_d.ill  = in_valid & zero_mode & dst_mem;
        wb_d.exc  = in_valid & exc_raw;
        wb_d.flt  = in_valid ? fault_raw : '0;
        wb_d.ben  = (in_valid && dst_mem && !zero_mode) ? byte_live : '0;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wb_q <= '0;
            end else begin
                wb_q <= wb_d;
            end
        end
    end else begin : g_comb
        assign wb_q = wb_d;
    end

    assign out_valid    = wb_q.vld;
    assign wr_data      = wb_q.data;
    assign byte_en      = wb_q.ben;
    assign exc_any      = wb_q.exc;
    assign fault_kept   = wb_q.flt;
    assign illegal_mode = wb_q.ill;

endmodule

// File: rtl/vpw_checker.sv
module vpw_checker #(
    parameter int VBITS   = 512,
    parameter bit OUT_REG = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [1:0]           esize,
    input logic                 zero_mode,
    input logic                 dst_mem,
    input logic [VBITS/8-1:0]   mask,
    input logic [VBITS-1:0]     result,
    input logic [VBITS-1:0]     old_dst,
    input logic [VBITS/8-1:0]   elem_exc,
    input logic [VBITS/8-1:0]   elem_fault,
    input logic                 out_valid,
    input logic [VBITS-1:0]     wr_data,
    input logic [VBITS/8-1:0]   byte_en,
    input logic                 exc_any,
    input logic [VBITS/8-1:0]   fault_kept,
    input logic                 illegal_mode
);
    localparam int NBYTES = VBITS / 8;

    logic              p_valid;
    logic [1:0]        p_esize;
    logic              p_zero;
    logic              p_mem;
    logic [NBYTES-1:0] p_mask;
    logic [VBITS-1:0]  p_result;
    logic [VBITS-1:0]  p_old;
    logic [NBYTES-1:0] p_fault;

    // align the request with the outputs it produced
    if (OUT_REG) begin : g_lag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_valid  <= 1'b0;
                p_esize  <= '0;
                p_zero   <= 1'b0;
                p_mem    <= 1'b0;
                p_mask   <= '0;
                p_result <= '0;
                p_old    <= '0;
                p_fault  <= '0;
            end else begin
                p_valid  <= in_valid;
                p_esize  <= esize;
                p_zero   <= zero_mode;
                p_mem    <= dst_mem;
                p_mask   <= mask;
                p_result <= result;
                p_old    <= old_dst;
                p_fault  <= elem_fault;
            end
        end
    end else begin : g_now
        assign p_valid  = in_valid;
        assign p_esize  = esize;
        assign p_zero   = zero_mode;
        assign p_mem    = dst_mem;
        assign p_mask   = mask;
        assign p_result = result;
        assign p_old    = old_dst;
        assign p_fault  = elem_fault;
    end

    AST_WIDE_ELEM_HIGH_FAULT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_esize == 2'd3) |-> (fault_kept[NBYTES-1:NBYTES/8] == '0)); // R1
    AST_EMPTY_MASK_MERGE_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_mask == '0 && (!p_zero || p_mem)) |-> (wr_data == p_old)); // R3
    AST_EMPTY_MASK_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_mask == '0 && p_zero && !p_mem) |-> (wr_data == '0)); // R4
    AST_REG_DEST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_mem) |-> (byte_en == '0)); // R5
    AST_ILLEGAL_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode == (p_valid && p_zero && p_mem)); // R6
    AST_ILLEGAL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode |-> (byte_en == '0)); // R6
    AST_EMPTY_MASK_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (p_mask == '0) |-> !exc_any); // R7
    AST_FAULT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_kept & ~(p_fault & p_mask)) == '0)); // R8
    AST_FULL_MASK_PASSES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && (&p_mask)) |-> (wr_data == p_result)); // R9
    AST_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == p_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (byte_en == '0 && !exc_any && fault_kept == '0 && !illegal_mode)); // R11

endmodule

bind vec_pred_writeback vpw_checker #(.VBITS(VBITS), .OUT_REG(OUT_REG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .esize        (esize),
    .zero_mode    (zero_mode),
    .dst_mem      (dst_mem),
    .mask         (mask),
    .result       (result),
    .old_dst      (old_dst),
    .elem_exc     (elem_exc),
    .elem_fault   (elem_fault),
    .out_valid    (out_valid),
    .wr_data      (wr_data),
    .byte_en      (byte_en),
    .exc_any      (exc_any),
    .fault_kept   (fault_kept),
    .illegal_mode (illegal_mode)
);

// File: tb/vec_pred_writeback_tb.sv
module vec_pred_writeback_tb;
    localparam int VB = 512;
    localparam int NB = VB / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    esize = '0;
    logic          zero_mode = 1'b0;
    logic          dst_mem = 1'b0;
    logic [NB-1:0] mask = '0;
    logic [VB-1:0] result = '0;
    logic [VB-1:0] old_dst = '0;
    logic [NB-1:0] elem_exc = '0;
    logic [NB-1:0] elem_fault = '0;

    logic          r_vld, c_vld, r_exc, c_exc, r_ill, c_ill;
    logic [VB-1:0] r_data, c_data;
    logic [NB-1:0] r_ben, c_ben, r_flt, c_flt;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    vec_pred_writeback #(.VBITS(VB), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esize(esize),
        .zero_mode(zero_mode), .dst_mem(dst_mem), .mask(mask), .result(result),
        .old_dst(old_dst), .elem_exc(elem_exc), .elem_fault(elem_fault),
        .out_valid(r_vld), .wr_data(r_data), .byte_en(r_ben), .exc_any(r_exc),
        .fault_kept(r_flt), .illegal_mode(r_ill)
    );

    vec_pred_writeback #(.VBITS(VB), .OUT_REG(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esize(esize),
        .zero_mode(zero_mode), .dst_mem(dst_mem), .mask(mask), .result(result),
        .old_dst(old_dst), .elem_exc(elem_exc), .elem_fault(elem_fault),
        .out_valid(c_vld), .wr_data(c_data), .byte_en(c_ben), .exc_any(c_exc),
        .fault_kept(c_flt), .illegal_mode(c_ill)
    );

    // expected values of the most recent request (compared to the registered copy next cycle)
    logic          e_vld = 1'b0;
    logic [VB-1:0] e_data = '0;
    logic [NB-1:0] e_ben = '0;
    logic          e_exc = 1'b0;
    logic [NB-1:0] e_flt = '0;
    logic          e_ill = 1'b0;

    task automatic chk(input string tag, input logic [VB-1:0] act, input logic [VB-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model();
        int w = 1 << esize;
        int cnt = NB / w;
        e_vld = in_valid;
        e_exc = 1'b0;
        e_ill = in_valid && zero_mode && dst_mem;
        for (int b = 0; b < NB; b++) begin
            logic on = mask[b / w];
            if (on) e_data[b*8 +: 8] = result[b*8 +: 8];
            else if (zero_mode && !dst_mem) e_data[b*8 +: 8] = 8'h00;
            else e_data[b*8 +: 8] = old_dst[b*8 +: 8];
            e_ben[b] = in_valid && dst_mem && !zero_mode && on;
        end
        for (int e = 0; e < NB; e++) begin
            logic en = (e < cnt) && mask[e];
            if (en && elem_exc[e] && in_valid) e_exc = 1'b1;
            e_flt[e] = in_valid && en && elem_fault[e];
        end
    endtask

    task automatic compare(input string who, input logic vld, input logic [VB-1:0] data,
                           input logic [NB-1:0] ben, input logic exc, input logic [NB-1:0] flt,
                           input logic ill);
        chk({who, " R10 valid"}, VB'(vld), VB'(e_vld));
        if (e_vld) chk({who, " R2 R3 R4 R9 data"}, data, e_data);
        chk({who, " R5 R6 R11 strobes"}, VB'(ben), VB'(e_ben));
        chk({who, " R7 R11 exc"}, VB'(exc), VB'(e_exc));
        chk({who, " R1 R8 R11 faults"}, VB'(flt), VB'(e_flt));
        chk({who, " R6 illegal"}, VB'(ill), VB'(e_ill));
    endtask

    // called at a falling edge: check last request on the registered copy, apply the new one
    task automatic apply(input logic v, input logic [1:0] es, input logic zm, input logic dm,
                         input logic [NB-1:0] m, input logic [VB-1:0] res, input logic [VB-1:0] od,
                         input logic [NB-1:0] ex, input logic [NB-1:0] fl);
        @(negedge clk);
        compare("reg", r_vld, r_data, r_ben, r_exc, r_flt, r_ill);
        in_valid = v; esize = es; zero_mode = zm; dst_mem = dm; mask = m;
        result = res; old_dst = od; elem_exc = ex; elem_fault = fl;
        #1;
        model();
        compare("comb", c_vld, c_data, c_ben, c_exc, c_flt, c_ill);
    endtask

    function automatic logic [VB-1:0] rnd_vec();
        logic [VB-1:0] r;
        for (int k = 0; k < VB / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [NB-1:0] rnd_m();
        return {$urandom, $urandom};
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [VB-1:0] res_a;
        logic [VB-1:0] old_a;
        res_a = rnd_vec();
        old_a = rnd_vec();
        repeat (3) @(negedge clk);
        // R10: registered outputs cleared during reset
        chk("R10 reset valid", VB'(r_vld), '0);
        chk("R10 reset strobes", VB'(r_ben), '0);
        chk("R10 reset faults", VB'(r_flt), '0);
        chk("R10 reset exc/illegal", VB'({r_exc, r_ill}), '0);
        rst_n = 1'b1;
        // each element width, both modes, both destinations, alternating mask
        for (int es = 0; es < 4; es++)
            for (int md = 0; md < 4; md++)
                apply(1'b1, 2'(es), md[0], md[1], {32{2'b10}}, res_a, old_a, '1, '1);
        // R9: all ones mask in every mode
        for (int md = 0; md < 4; md++)
            apply(1'b1, 2'(md), md[0], md[1], '1, rnd_vec(), rnd_vec(), '0, '0);
        // R3 R4: empty mask, exceptions and faults on every element (R7 R8)
        apply(1'b1, 2'd0, 1'b0, 1'b0, '0, res_a, old_a, '1, '1);
        apply(1'b1, 2'd1, 1'b1, 1'b0, '0, res_a, old_a, '1, '1);
        apply(1'b1, 2'd2, 1'b0, 1'b1, '0, res_a, old_a, '1, '1);
        // R1: 64-bit elements, only high mask bits set, flags only on high slots
        apply(1'b1, 2'd3, 1'b1, 1'b0, {56'hFF_FFFF_FFFF_FFFF, 8'h00}, res_a, old_a,
              {56'hFF_FFFF_FFFF_FFFF, 8'h00}, {56'hFF_FFFF_FFFF_FFFF, 8'h00});
        apply(1'b1, 2'd3, 1'b0, 1'b1, {56'hFF_FFFF_FFFF_FFFF, 8'h05}, res_a, old_a, '1, '1);
        // R11: idle cycles with live-looking data
        apply(1'b0, 2'd0, 1'b1, 1'b1, '1, res_a, old_a, '1, '1);
        apply(1'b0, 2'd2, 1'b0, 1'b1, '1, res_a, old_a, '1, '1);
        // random traffic with varied mask density
        for (int n = 0; n < 600; n++) begin
            logic [NB-1:0] m;
            case ($urandom % 4)
                0: m = '0;
                1: m = '1;
                2: m = rnd_m() & rnd_m();
                default: m = rnd_m();
            endcase
            apply(($urandom % 8) != 0, 2'($urandom), 1'($urandom), 1'($urandom), m,
                  rnd_vec(), rnd_vec(), rnd_m() & rnd_m(), rnd_m());
        end
        apply(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
        apply(1'b0, 2'd0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule